// File: doc/BRIEF.md
# Infrared Carrier Output Generator

This block produces the drive signal for an infrared emitter diode. It runs on the system clock (half the oscillator frequency) and divides it by one of eight ratios, picked by a 3-bit select code, to make a carrier whose active part lasts one third of each period. Two control bits gate it. A level bit turns the emitter on. A carrier enable bit picks between a modulated burst and a steady level. A polarity bit picks whether the emitter is driven by a high or by a low level.

While either control bit is 0, the divider is held at count zero. A burst therefore always opens with a complete active phase. The select code is taken while the divider is stopped and again at each period wrap, so a new code never cuts a period short. As an example, a 4 MHz oscillator gives a 2 MHz system clock, and ratio 53 then gives a carrier of about 37.74 kHz. The select code and the polarity bit are static configuration inputs. Register decode and the pad driver sit outside the block.

Top module: `ir_carrier_gen`

## Requirements
- R1: The select code gives the period N in system clocks: code 0 gives 6, 1 gives 36, 2 gives 50, 3 gives 53, 4 gives 56, 5 gives 61, 6 gives 64 and 7 gives 74.
- R2: Each carrier period lasts N clocks. Its active phase is the first floor(N/3) clocks, counted from the period's first clock, and the idle phase fills the remaining clocks.
- R3: With polarity 0, the output is 1 while the level bit is 0. With the level bit at 1 and carrier enable at 0, the output is a steady 0. With both at 1, the output is 0 in the active phase and 1 in the idle phase.
- R4: With polarity 1, the output is 0 while the level bit is 0. With the level bit at 1 and carrier enable at 0, the output is a steady 1. With both at 1, the output is 1 in the active phase and 0 in the idle phase.
- R5: While the level bit or carrier enable is 0, the divider is held at zero. The first clock in which both are 1 is the first clock of a complete period, and the active phase starts in that clock.
- R6: The select code is sampled at every clock edge while the divider is stopped, and at the edge that ends a period. A change made in the middle of a period takes effect with the next period.
- R7: During reset and after it, the divider is at zero and the latched code is 0. The output follows R3 and R4 throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (oscillator / 2) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_code | input | 3 | Carrier ratio select code |
| polarity | input | 1 | 0: emitter driven by low level, 1: by high level |
| level_on | input | 1 | Emitter on request (control bit 1) |
| carrier_en | input | 1 | Carrier modulation enable (control bit 0) |
| ir_drive | output | 1 | Emitter drive signal |

## Verification
The hardest conditions to reach are a select-code change that lands exactly one clock before a period wrap, and a gating bit dropped and restored partway through an active phase. Only particular clock positions inside a 6 to 74 clock period expose them. Directed sequences place a code change in the middle of a long period and a re-enable in the middle of a burst. A long random run then toggles the code and the gating bits at low rates. Over that run the changes fall on every position within a period, including the wrap clock, and a bench model checks the output in every cycle.

// File: rtl/ircg_pkg.sv
package ircg_pkg;
  localparam int SEL_W = 3;

  // Carrier period in system clocks for each select code
  function automatic int unsigned ircg_ratio(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    return 6;
      3'd1:    return 36;
      3'd2:    return 50;
      3'd3:    return 53;
      3'd4:    return 56;
      3'd5:    return 61;
      3'd6:    return 64;
      default: return 74;
    endcase
  endfunction

  // Length of the active phase: one third of the period, rounded down
  function automatic int unsigned ircg_active(input int unsigned period);
    return period / 3;
  endfunction
endpackage

// File: rtl/ircg_divider.sv
module ircg_divider
  import ircg_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic [SEL_W-1:0] code_q,
  output logic             wrap
);
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'(ircg_ratio(code_q) - 1);
  assign wrap     = run && (cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      code_q <= '0;
    end else if (!run || wrap) begin
      cnt    <= '0;
      code_q <= sel;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ircg_shaper.sv
module ircg_shaper
  import ircg_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] code_q,
  input  logic             level_on,
  input  logic             carrier_en,
  input  logic             polarity,
  output logic             carrier_on,
  output logic             ir_drive
);
  logic [CNT_W-1:0] act_len;
  logic             emit;

  assign act_len    = CNT_W'(ircg_active(ircg_ratio(code_q)));
  assign carrier_on = cnt < act_len;
  assign emit       = level_on && (!carrier_en || carrier_on);
  assign ir_drive   = emit ? polarity : !polarity;
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ircg_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_code,
  input  logic       polarity,
  input  logic       level_on,
  input  logic       carrier_en,
  output logic       ir_drive
);
  logic             run;
  logic             wrap;
  logic             carrier_on;
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] code_q;

  assign run = level_on && carrier_en;

  ircg_divider #(.CNT_W(CNT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .sel    (sel_code),
    .cnt    (cnt),
    .code_q (code_q),
    .wrap   (wrap)
  );

  ircg_shaper #(.CNT_W(CNT_W)) u_shape (
    .cnt        (cnt),
    .code_q     (code_q),
    .level_on   (level_on),
    .carrier_en (carrier_en),
    .polarity   (polarity),
    .carrier_on (carrier_on),
    .ir_drive   (ir_drive)
  );
endmodule

// File: rtl/ir_carrier_gen_chk.sv
module ir_carrier_gen_chk
  import ircg_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             wrap,
  input logic             level_on,
  input logic             carrier_en,
  input logic             polarity,
  input logic             ir_drive,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] code_q
);
  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(ircg_ratio(code_q)));

  assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  assert_steady_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !level_on |-> (ir_drive == !polarity));

  assert_unmodulated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_on && !carrier_en) |-> (ir_drive == polarity));

  assert_hold_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  assert_start_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));

  assert_code_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(code_q));
endmodule

bind ir_carrier_gen ir_carrier_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .wrap       (wrap),
  .level_on   (level_on),
  .carrier_en (carrier_en),
  .polarity   (polarity),
  .ir_drive   (ir_drive),
  .cnt        (cnt),
  .code_q     (code_q)
);

// File: tb/ir_carrier_gen_test.sv
`timescale 1ns/1ps
module ir_carrier_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel_code = 3'd0;
  logic       polarity = 1'b0;
  logic       level_on = 1'b0;
  logic       carrier_en = 1'b0;
  logic       ir_drive;

  int checks = 0;
  int failures = 0;
  int m_pos = 0;
  int m_per = 6;

  always #2.5 clk = ~clk;

  ir_carrier_gen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_code   (sel_code),
    .polarity   (polarity),
    .level_on   (level_on),
    .carrier_en (carrier_en),
    .ir_drive   (ir_drive)
  );

  // Period table of R1 held as bench data
  function automatic int b_period(input logic [2:0] c);
    int tbl [8] = '{6, 36, 50, 53, 56, 61, 64, 74};
    return tbl[c];
  endfunction

  function automatic logic b_expect(input int pos, input int per);
    logic act;
    act = level_on && (!carrier_en || (pos * 3 < per - (per % 3)));
    return act ? polarity : !polarity;
  endfunction

  // Check the output for the current inputs, advance the model, move to next cycle
  task automatic cyc(input string tag);
    logic exp_v;
    #1;
    exp_v = b_expect(m_pos, m_per);
    checks++;
    if (ir_drive !== exp_v) begin
      failures++;
      $display("FAIL %s: ir_drive=%b expected=%b (pos=%0d per=%0d)",
               tag, ir_drive, exp_v, m_pos, m_per);
    end
    if (!rst_n) begin
      m_pos = 0; m_per = 6;
    end else if (!(level_on && carrier_en) || m_pos == m_per - 1) begin
      m_pos = 0; m_per = b_period(sel_code);
    end else begin
      m_pos++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R7: reset state, both polarities and gating combinations
    for (int i = 0; i < 8; i++) begin
      polarity = i[0]; level_on = i[1]; carrier_en = i[2];
      cyc("R7");
    end
    level_on = 1'b0; carrier_en = 1'b0; polarity = 1'b0;
    cyc("R7");
    rst_n = 1'b1;
    cyc("R7");

    // R1 R2: every select code, two full periods from a clean start
    for (int c = 0; c < 8; c++) begin
      sel_code = 3'(c); polarity = c[0]; level_on = 1'b0; carrier_en = 1'b0;
      cyc("R1 R2");
      level_on = 1'b1; carrier_en = 1'b1;
      for (int k = 0; k < 2 * b_period(3'(c)) + 2; k++) cyc("R1 R2");
    end

    // R5: drop carrier enable inside an active phase, then restore it
    level_on = 1'b0; sel_code = 3'd3; polarity = 1'b1;
    cyc("R5");
    level_on = 1'b1; carrier_en = 1'b1;
    for (int k = 0; k < 10; k++) cyc("R5");
    carrier_en = 1'b0;
    for (int k = 0; k < 3; k++) cyc("R5");
    carrier_en = 1'b1;
    for (int k = 0; k < 40; k++) cyc("R5");
    level_on = 1'b0;
    cyc("R5");
    level_on = 1'b1;
    for (int k = 0; k < 25; k++) cyc("R5");

    // R6: code change in the middle of a long period
    level_on = 1'b0; sel_code = 3'd7; polarity = 1'b0;
    cyc("R6");
    level_on = 1'b1;
    for (int k = 0; k < 30; k++) cyc("R6");
    sel_code = 3'd0;
    for (int k = 0; k < 70; k++) cyc("R6");
    sel_code = 3'd2;
    for (int k = 0; k < 10; k++) cyc("R6");

    // Random run, checks tagged by the truth-table branch in use
    for (int k = 0; k < 30000; k++) begin
      if ($urandom_range(39) == 0) sel_code = 3'($urandom_range(7));
      if ($urandom_range(59) == 0) level_on = !level_on;
      if ($urandom_range(59) == 0) carrier_en = !carrier_en;
      if ($urandom_range(499) == 0) polarity = !polarity;
      if (polarity) cyc("R4");
      else          cyc("R3");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule